// File: doc/BRIEF.md
# Hardware Cursor Overlay Stage

This block sits in a display pipeline and lays a small two-bit-per-pixel cursor over the stream of pixels. A host fills a local 64x64 cursor bitmap one byte at a time. Each pixel of the bitmap is a 2-bit code, and four codes are packed into each byte. The host also programs an enable bit, the cursor's top-left position on screen and three 16-bit RGB565 colours. These are written through a small configuration port that a register select field steers.

On every cycle the pipeline presents the current beam coordinates and the pixel that lies underneath. The stage checks whether the beam falls inside the 64x64 cursor window. If it does, the stage reads the code for that spot from the bitmap. One cycle later it outputs one of two things. Either it passes the underlying pixel through, when the code is transparent or the beam is outside the window, or it outputs the chosen cursor colour widened to 8 bits per channel.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the overlay is disabled, the position is (0,0) and all colours are zero. The output then reproduces the input pixel, even at beam (0,0).
- R2: `pixOut` always reflects the inputs presented one clock cycle earlier. When the overlay is not applied, `pixOut` equals the `pixIn` of the previous cycle.
- R3: Select code 0 writes the enable register, and only data bit 0 is used. When that bit is 0, no cursor pixel is ever output.
- R4: Select code 1 writes the position: x from data bits 10:0 and y from data bits 26:16. Data bits 15:11 and 31:27 have no effect.
- R5: The cursor is applied only when 0 <= beamX-x <= 63 and 0 <= beamY-y <= 63 (inclusive on both edges). The window is clipped at coordinate 2047.
- R6: The bitmap code for relative pixel (rx,ry) sits at byte address ry*16 + rx/4, in bits 2*(rx mod 4)+1 : 2*(rx mod 4). The lowest bit pair is the leftmost pixel.
- R7: Code 0 is transparent, so the underlying pixel is output.
- R8: Code 1 selects the low 16 bits and code 2 the high 16 bits of the word written with select code 2. Code 3 selects the low 16 bits of the word written with select code 3.
- R9: A colour is RGB565 (red 15:11, green 10:5, blue 4:0). Each channel is widened to 8 bits by appending its own top bits. The output packs red in 23:16, green in 15:8 and blue in 7:0.
- R10: A host bitmap write is visible to a lookup presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 enable, 1 position, 2 colours 1/2, 3 colour 3 |
| cfgWrData | input | 32 | Configuration write data |
| hostWrEn | input | 1 | Bitmap byte write strobe |
| hostWrAddr | input | 10 | Bitmap byte address |
| hostWrData | input | 8 | Bitmap byte data (four packed 2-bit codes) |
| beamX | input | 11 | Current beam column |
| beamY | input | 11 | Current beam row |
| pixIn | input | 24 | Underlying pixel, 8:8:8 RGB |
| pixOut | output | 24 | Composited pixel, one cycle after the inputs |

## Verification
The bitmap is filled with an arithmetic byte pattern so that every code value appears at every pair position. A full sweep then covers the window plus a margin of a few pixels on each side. This tells apart errors in the byte address, in the bit-pair order, in the code-to-colour mapping and in the off-by-one edges of the window. A second sweep at a position near the far screen corner checks clipping at 2047. A repeat of the position write with junk in the unused bits shows that those bits are ignored. Sweeps with the enable bit cleared, and a byte written just before its lookup, separate gating from read-after-write timing.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  // Cursor edge is 2**CUR_LOG2 pixels; codes are 2 bits, four per byte.
  localparam int CUR_LOG2   = 6;
  localparam int CUR_ADDR_W = 2 * CUR_LOG2 - 2;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_POS    = 2'd1,
    CFG_COL12  = 2'd2,
    CFG_COL3   = 2'd3
  } cfgSel_e;

  // Strobes and lookup coordinates from control to datapath.
  typedef struct packed {
    logic                colPairWr;
    logic                colThirdWr;
    logic                overlayHit;
    logic [CUR_LOG2-1:0] relX;
    logic [CUR_LOG2-1:0] relY;
  } ctrlStrobe_t;

endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
#(
  parameter int BEAM_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgWrData,
  input  logic [BEAM_W-1:0] beamX,
  input  logic [BEAM_W-1:0] beamY,
  output ctrlStrobe_t       strb
);

  localparam int DIFF_W = BEAM_W + 1;

  cfgSel_e           selQ;
  logic              curEn;
  logic [BEAM_W-1:0] posX;
  logic [BEAM_W-1:0] posY;
  logic [DIFF_W-1:0] diffX;
  logic [DIFF_W-1:0] diffY;
  logic              inWinX;
  logic              inWinY;
  logic              unusedCfgBits;

  assign selQ = cfgSel_e'(cfgSel);
  assign unusedCfgBits = ^{cfgWrData[31:16+BEAM_W], cfgWrData[15:BEAM_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curEn <= 1'b0;
      posX  <= '0;
      posY  <= '0;
    end else if (cfgWrEn) begin
      case (selQ)
        CFG_ENABLE: curEn <= cfgWrData[0];
        CFG_POS: begin
          posX <= cfgWrData[BEAM_W-1:0];
          posY <= cfgWrData[16+BEAM_W-1:16];
        end
        default: ;
      endcase
    end
  end

  // Window test: the difference must be non-negative and below the edge size.
  assign diffX  = {1'b0, beamX} - {1'b0, posX};
  assign diffY  = {1'b0, beamY} - {1'b0, posY};
  assign inWinX = (diffX[DIFF_W-1:CUR_LOG2] == '0);
  assign inWinY = (diffY[DIFF_W-1:CUR_LOG2] == '0);

  always_comb begin
    strb.colPairWr  = cfgWrEn && (selQ == CFG_COL12);
    strb.colThirdWr = cfgWrEn && (selQ == CFG_COL3);
    strb.overlayHit = curEn && inWinX && inWinY;
    strb.relX       = diffX[CUR_LOG2-1:0];
    strb.relY       = diffY[CUR_LOG2-1:0];
  end

  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    strb.overlayHit |-> curEn); // R3

  AST_LEFT_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (beamX < posX) |-> !strb.overlayHit); // R5

  AST_ABOVE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (beamY < posY) |-> !strb.overlayHit); // R5

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && cfgSel == 2'd1) |=> $stable({posX, posY})); // R4

endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [31:0]           cfgWrData,
  input  logic                  hostWrEn,
  input  logic [CUR_ADDR_W-1:0] hostWrAddr,
  input  logic [7:0]            hostWrData,
  input  logic [PIX_W-1:0]      pixIn,
  output logic [PIX_W-1:0]      pixOut
);

  localparam int CH_W      = PIX_W / 3;
  localparam int MEM_BYTES = 1 << CUR_ADDR_W;

  logic [7:0]            bitmap [MEM_BYTES];
  logic [CUR_ADDR_W-1:0] rdAddr;
  logic [7:0]            rdByte;
  logic [1:0]            pairSelQ;
  logic                  hitQ;
  logic [PIX_W-1:0]      pixQ;
  logic [31:0]           colPair;
  logic [15:0]           colThird;
  logic [7:0]            shifted;
  logic [1:0]            code;
  logic [15:0]           sel565;
  logic [CH_W-1:0]       rExp;
  logic [CH_W-1:0]       gExp;
  logic [CH_W-1:0]       bExp;
  logic                  primed;
  logic                  unusedColBits;

  assign unusedColBits = ^cfgWrData[31:16];

  // Bitmap store: host write port and lookup read port.
  assign rdAddr = {strb.relY, strb.relX[CUR_LOG2-1:2]};

  always_ff @(posedge clk) begin
    if (hostWrEn) bitmap[hostWrAddr] <= hostWrData;
    rdByte <= bitmap[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ     <= 1'b0;
      pairSelQ <= '0;
      pixQ     <= '0;
      colPair  <= '0;
      colThird <= '0;
      primed   <= 1'b0;
    end else begin
      hitQ     <= strb.overlayHit;
      pairSelQ <= strb.relX[1:0];
      pixQ     <= pixIn;
      primed   <= 1'b1;
      if (strb.colPairWr)  colPair  <= cfgWrData;
      if (strb.colThirdWr) colThird <= cfgWrData[15:0];
    end
  end

  assign shifted = rdByte >> {pairSelQ, 1'b0};
  assign code    = shifted[1:0];

  always_comb begin
    case (code)
      2'd1:    sel565 = colPair[15:0];
      2'd2:    sel565 = colPair[31:16];
      default: sel565 = colThird;
    endcase
  end

  // Widen each channel by repeating its top bits into the low positions.
  for (genvar i = 0; i < CH_W; i++) begin : g_expand
    assign rExp[i] = sel565[15 - ((CH_W - 1 - i) % 5)];
    assign gExp[i] = sel565[10 - ((CH_W - 1 - i) % 6)];
    assign bExp[i] = sel565[4  - ((CH_W - 1 - i) % 5)];
  end

  assign pixOut = (hitQ && code != 2'd0) ? {rExp, gExp, bExp} : pixQ;

  AST_PASS_WHEN_MISS: assert property (@(posedge clk) disable iff (!rstN || !primed)
    !$past(strb.overlayHit) |-> pixOut == $past(pixIn)); // R2

  AST_CODE0_TRANSPARENT: assert property (@(posedge clk) disable iff (!rstN)
    (code == 2'd0) |-> pixOut == pixQ); // R7

  AST_COL3_RED_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (hitQ && code == 2'd3) |-> pixOut[PIX_W-1 -: 5] == colThird[15:11]); // R9

  AST_COL3_BLUE_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (hitQ && code == 2'd3) |-> pixOut[CH_W-1 -: 5] == colThird[4:0]); // R8

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int BEAM_W = 11,
  parameter int PIX_W  = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [1:0]            cfgSel,
  input  logic [31:0]           cfgWrData,
  input  logic                  hostWrEn,
  input  logic [CUR_ADDR_W-1:0] hostWrAddr,
  input  logic [7:0]            hostWrData,
  input  logic [BEAM_W-1:0]     beamX,
  input  logic [BEAM_W-1:0]     beamY,
  input  logic [PIX_W-1:0]      pixIn,
  output logic [PIX_W-1:0]      pixOut
);

  ctrlStrobe_t strb;

  cursor_ctrl #(.BEAM_W(BEAM_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .beamX     (beamX),
    .beamY     (beamY),
    .strb      (strb)
  );

  cursor_datapath #(.PIX_W(PIX_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgWrData  (cfgWrData),
    .hostWrEn   (hostWrEn),
    .hostWrAddr (hostWrAddr),
    .hostWrData (hostWrData),
    .pixIn      (pixIn),
    .pixOut     (pixOut)
  );

endmodule

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        hostWrEn = 1'b0;
  logic [9:0]  hostWrAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic [10:0] beamX = '0;
  logic [10:0] beamY = '0;
  logic [23:0] pixIn = '0;
  logic [23:0] pixOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side view of programmed state, taken from the requirements.
  logic [7:0]  memModel [1024];
  bit          mEn = 1'b0;
  int          mPx = 0;
  int          mPy = 0;
  logic [15:0] mC1 = '0, mC2 = '0, mC3 = '0;

  always #2.5 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .hostWrData(hostWrData), .beamX(beamX), .beamY(beamY),
    .pixIn(pixIn), .pixOut(pixOut)
  );

  function automatic logic [23:0] widen(logic [15:0] c);
    int r = (c >> 11) & 31;
    int g = (c >> 5) & 63;
    int b = c & 31;
    int r8 = (r << 3) | (r >> 2);
    int g8 = (g << 2) | (g >> 4);
    int b8 = (b << 3) | (b >> 2);
    return 24'((r8 << 16) | (g8 << 8) | b8);
  endfunction

  function automatic logic [23:0] model(int x, int y, logic [23:0] pix);
    int dx = x - mPx;
    int dy = y - mPy;
    int cd;
    if (!mEn || dx < 0 || dx > 63 || dy < 0 || dy > 63) return pix;
    cd = (memModel[dy*16 + dx/4] >> (2*(dx % 4))) & 3;
    case (cd)
      1: return widen(mC1);
      2: return widen(mC2);
      3: return widen(mC3);
      default: return pix;
    endcase
  endfunction

  task automatic cfgWrite(int sel, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 2'(sel); cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    case (sel)
      0: mEn = data[0];
      1: begin mPx = int'(data[10:0]); mPy = int'(data[26:16]); end
      2: begin mC1 = data[15:0]; mC2 = data[31:16]; end
      default: mC3 = data[15:0];
    endcase
  endtask

  task automatic memWrite(int addr, logic [7:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrAddr = 10'(addr); hostWrData = data;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
    memModel[addr] = data;
  endtask

  task automatic probe(int x, int y, logic [23:0] pix, string req);
    logic [23:0] exp;
    @(negedge clk);
    beamX = 11'(x); beamY = 11'(y); pixIn = pix;
    exp = model(x, y, pix);
    @(posedge clk); #1;
    checks++;
    if (pixOut !== exp) begin
      fails++;
      $display("FAIL %s at (%0d,%0d): actual %06h expected %06h", req, x, y, pixOut, exp);
    end
  endtask

  task automatic sweep(int x0, int x1, int y0, int y1, string req);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        probe(x, y, 24'((x * 7919) ^ (y * 104729)), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: after reset, disabled; beam at origin passes through.
    probe(0, 0, 24'h123456, "R1");
    probe(5, 5, 24'hABCDEF, "R1");
    probe(63, 63, 24'h0F0F0F, "R2");

    // Fill bitmap with a pattern covering all codes at all pair slots.
    for (int a = 0; a < 1024; a++)
      memWrite(a, 8'((a * 29 + (a >> 4) * 7 + 3) & 255));

    cfgWrite(2, {16'h07E0, 16'hA5C3}); // R8 colour 1 low, colour 2 high
    cfgWrite(3, {16'hFFFF, 16'h5B2D}); // R8 colour 3, upper half unused
    probe(120, 60, 24'h777777, "R3");   // still disabled

    cfgWrite(0, 32'h1);
    cfgWrite(1, (32'd50 << 16) | 32'd100);
    // R5 R6 R7 R8 R9: window plus margin
    sweep(95, 168, 46, 117, "R6");

    // R4: junk in unused position bits must not shift the window.
    cfgWrite(1, (32'd50 << 16) | 32'd100 | 32'hF800_F800);
    mPx = 100; mPy = 50;
    sweep(98, 165, 49, 51, "R4");

    // R5: clipping near the far corner.
    cfgWrite(1, (32'd2040 << 16) | 32'd1990);
    sweep(1985, 2047, 2035, 2047, "R5");

    // R3: enable bit cleared, extra bits set but bit 0 low.
    cfgWrite(0, 32'hFFFF_FFFE);
    cfgWrite(1, 32'd0);
    sweep(0, 9, 0, 3, "R3");
    cfgWrite(0, 32'h0000_0001);

    // R10: byte written just before lookup; codes 0..3 left to right.
    memWrite(0, 8'b11_10_01_00);
    probe(0, 0, 24'h010203, "R10");
    probe(1, 0, 24'h010203, "R10");
    probe(2, 0, 24'h010203, "R10");
    probe(3, 0, 24'h010203, "R10");
    memWrite(0, 8'h00);
    probe(3, 0, 24'h445566, "R7");

    // R9: extreme colours for widening.
    cfgWrite(3, 32'h0000_F81F);
    memWrite(1, 8'hFF);
    probe(4, 0, 24'h000000, "R9");
    cfgWrite(3, 32'h0000_0000);
    probe(5, 0, 24'hFFFFFF, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule